// File: doc/BRIEF.md
# PLL-Aware Two-Domain Reset Sequencer

This block produces the reset signals for logic that runs on two phase-aligned clocks from a PLL. The slow clock runs at half the rate of the fast clock, and their rising edges coincide. The block takes four inputs: an external asynchronous active-low reset, the PLL lock flag and both clocks. It drives three outputs: a reset request back to the PLL, an active-low reset for the slow domain, and an active-low reset for the fast domain. The fast-domain reset is the one that fabric logic should use.

Any reset cause clears both domain resets at once, with no clock needed. The two causes are the external reset going low and the lock flag going low. Release happens only once the external reset is high and the PLL reports lock. The slow domain releases first, after a resynchronising chain and a hold counter. The fast domain then releases after its own resynchronising chain, which takes the slow-domain reset as its input. When the PLL loses lock after it had locked, the block requests a PLL reset of fixed minimum length. The full release sequence then runs again once lock returns.

Top module: `rst_seq_top`

## Requirements
- R1: When `ext_rst_n` is low or `pll_locked` is low, `slow_rst_n` and `fast_rst_n` are both low, and they go low without waiting for a clock edge.
- R2: `slow_rst_n` rises on exactly the (SYNC_STAGES + HOLD_CYCLES)-th rising edge of `clk_slow` after the later of `ext_rst_n` high and `pll_locked` high.
- R3: `fast_rst_n` rises on exactly the SYNC_STAGES-th rising edge of `clk_fast` that follows the edge on which `slow_rst_n` rose. `fast_rst_n` is never high while `slow_rst_n` is low.
- R4: Neither domain reset is released while `pll_locked` is low. A high `pll_locked` while `ext_rst_n` is low does not release either of them.
- R5: If lock drops during the hold count, the count starts again from zero. The next release then takes the full R2 latency, measured from the return of lock.
- R6: `pll_rst_req` is high while `ext_rst_n` is low. It stays high for exactly PULSE_CYCLES rising edges of `clk_fast` after `ext_rst_n` goes high, and it is low on the last of those edges.
- R7: After `pll_locked` has been seen high, a fall of `pll_locked` raises `pll_rst_req` on the (SYNC_STAGES + 1)-th rising edge of `clk_fast`. The request then stays high for PULSE_CYCLES fast edges.
- R8: A loss-of-lock request fires only once. It does not fire again while `pll_locked` stays low, and it can fire again only after lock has been seen high once more.
- R9: Every rise of `slow_rst_n` coincides with a rising edge of `clk_slow`, and every rise of `fast_rst_n` coincides with a rising edge of `clk_fast`.
- R10: While `ext_rst_n` is held low, the outputs are `slow_rst_n` = 0, `fast_rst_n` = 0 and `pll_rst_req` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow PLL output clock, half the rate of clk_fast, rising edges aligned |
| clk_fast | input | 1 | Fast PLL output clock |
| ext_rst_n | input | 1 | External asynchronous reset, active low |
| pll_locked | input | 1 | PLL lock indication, high when locked |
| pll_rst_req | output | 1 | Reset request to the PLL, active high |
| slow_rst_n | output | 1 | Slow-domain reset, active low |
| fast_rst_n | output | 1 | Fast-domain reset for all fabric logic, active low |

## Verification
The bench builds the block with SYNC_STAGES = 2, HOLD_CYCLES = 5 and PULSE_CYCLES = 4. This makes the expected latencies short enough to count edge by edge: 7 slow edges to slow release, 2 fast edges to fast release, and 3 fast edges to a loss-of-lock request. The bench sweeps the moment that lock arrives across every 1 ns position inside a slow-clock period. This shows that the release latency does not depend on the phase of the incoming condition. Further runs cover lock dropping in the middle of the count, lock dropping while running, and the external reset cutting in while running.

// File: rtl/rst_seq_pkg.sv
// Package: shared helpers for the reset sequencer.
// Assumes: counters hold values from 0 up to a positive limit.
package rst_seq_pkg;

    // Width needed to hold the values 0..n.
    function automatic int cnt_bits(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rst_sync_chain.sv
// Module: reset resynchroniser chain.
// Clearing is asynchronous through clr_n. Each clock edge shifts d in, so a
// rising input appears at q only after STAGES edges. That gives a metastable
// first stage time to settle. Assumes STAGES >= 2. The last stage drives a
// reset tree and must stay a single register.
module rst_sync_chain #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sr;

    // Shift register with asynchronous clear.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            sr <= '0;
        end else begin
            sr <= {sr[STAGES-2:0], d};
        end
    end

    assign q = sr[STAGES-1];

endmodule

// File: rtl/rst_hold_timer.sv
// Module: release hold counter.
// Once start is high, the module counts HOLD clock edges and then sets done.
// done stays set until clr_n clears it asynchronously, which also restarts
// the count from zero. Assumes HOLD >= 1.
module rst_hold_timer
    import rst_seq_pkg::*;
#(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic clr_n,
    input  logic start,
    output logic done
);

    localparam int W = cnt_bits(HOLD);
    localparam logic [W-1:0] LAST = W'(HOLD - 1);

    logic [W-1:0] cnt;

    // Count qualified edges, then latch done.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (start && !done) begin
            if (cnt == LAST) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pll_rst_ctl.sv
// Module: PLL reset request generator, clocked by the fast clock.
// The request is forced high asynchronously while ext_rst_n is low and held
// for PULSE edges after release. It also fires after a loss of lock, but
// only once lock has been seen since the last request. Assumes the fast
// clock keeps running while lock is low. Assumes SYNC >= 2 and PULSE >= 1.
module pll_rst_ctl
    import rst_seq_pkg::*;
#(
    parameter int SYNC  = 3,
    parameter int PULSE = 8
) (
    input  logic clk_fast,
    input  logic ext_rst_n,
    input  logic pll_locked,
    output logic pll_rst_req
);

    localparam int W = cnt_bits(PULSE);
    localparam logic [W-1:0] LEN = W'(PULSE);

    logic         lock_s;
    logic         seen;
    logic [W-1:0] remain;

    // Bring the lock flag into the fast domain.
    rst_sync_chain #(.STAGES(SYNC)) u_lock_sync (
        .clk   (clk_fast),
        .clr_n (ext_rst_n),
        .d     (pll_locked),
        .q     (lock_s)
    );

    // Pulse timer and lock-seen tracking.
    always_ff @(posedge clk_fast or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            remain <= LEN;
            seen   <= 1'b0;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end else if (seen && !lock_s) begin
            remain <= LEN;
            seen   <= 1'b0;
        end else if (lock_s) begin
            seen <= 1'b1;
        end
    end

    assign pll_rst_req = (remain != '0);

endmodule

// File: rtl/rst_seq_top.sv
// Module: two-domain reset sequencer for phase-aligned PLL clocks.
// Both domain resets are cleared asynchronously by (external reset OR not
// locked). The slow domain releases first, after a resynchroniser and a hold
// counter. The fast domain then resynchronises the slow reset. Assumes the
// slow clock is half the fast rate with aligned rising edges.
module rst_seq_top #(
    parameter int SYNC_STAGES  = 3,
    parameter int HOLD_CYCLES  = 16,
    parameter int PULSE_CYCLES = 8
) (
    input  logic clk_slow,
    input  logic clk_fast,
    input  logic ext_rst_n,
    input  logic pll_locked,
    output logic pll_rst_req,
    output logic slow_rst_n,
    output logic fast_rst_n
);

    logic arst_n;
    logic slow_sync_n;

    // Combined asynchronous reset cause.
    assign arst_n = ext_rst_n & pll_locked;

    // Slow domain: resynchronise the release, then hold.
    rst_sync_chain #(.STAGES(SYNC_STAGES)) u_slow_sync (
        .clk   (clk_slow),
        .clr_n (arst_n),
        .d     (1'b1),
        .q     (slow_sync_n)
    );

    rst_hold_timer #(.HOLD(HOLD_CYCLES)) u_hold (
        .clk   (clk_slow),
        .clr_n (arst_n),
        .start (slow_sync_n),
        .done  (slow_rst_n)
    );

    // Fast domain: its release is sourced from the slow-domain reset.
    rst_sync_chain #(.STAGES(SYNC_STAGES)) u_fast_sync (
        .clk   (clk_fast),
        .clr_n (arst_n),
        .d     (slow_rst_n),
        .q     (fast_rst_n)
    );

    // PLL reset request on external reset or loss of lock.
    pll_rst_ctl #(.SYNC(SYNC_STAGES), .PULSE(PULSE_CYCLES)) u_pll (
        .clk_fast    (clk_fast),
        .ext_rst_n   (ext_rst_n),
        .pll_locked  (pll_locked),
        .pll_rst_req (pll_rst_req)
    );

endmodule

// File: rtl/rst_seq_checker.sv
// Module: property checker for rst_seq_top, attached with bind.
module rst_seq_checker #(
    parameter int SYNC_STAGES  = 3,
    parameter int HOLD_CYCLES  = 16,
    parameter int PULSE_CYCLES = 8
) (
    input logic clk_slow,
    input logic clk_fast,
    input logic ext_rst_n,
    input logic pll_locked,
    input logic pll_rst_req,
    input logic slow_rst_n,
    input logic fast_rst_n
);

    localparam int HW = $clog2(PULSE_CYCLES + 2) + 1;
    localparam logic [HW-1:0] HMAX = '1;

    logic [HW-1:0] hi_cnt = '0;

    // Count consecutive fast edges with the PLL request high.
    always_ff @(posedge clk_fast) begin
        if (!pll_rst_req) begin
            hi_cnt <= '0;
        end else if (hi_cnt != HMAX) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    a_r1_unlock_holds_resets: assert property (@(posedge clk_fast) disable iff (!ext_rst_n)
        !pll_locked |-> (!slow_rst_n && !fast_rst_n));

    a_r3_fast_needs_slow: assert property (@(posedge clk_fast) disable iff (!ext_rst_n)
        fast_rst_n |-> slow_rst_n);

    a_r3_slow_led_fast: assert property (@(posedge clk_fast) disable iff (!ext_rst_n)
        $rose(fast_rst_n) |-> $past(slow_rst_n));

    a_r4_release_needs_lock: assert property (@(posedge clk_slow) disable iff (!ext_rst_n)
        slow_rst_n |-> pll_locked);

    a_r6_pll_pulse_min: assert property (@(posedge clk_fast) disable iff (!ext_rst_n)
        $fell(pll_rst_req) |-> (int'(hi_cnt) >= PULSE_CYCLES));

endmodule

bind rst_seq_top rst_seq_checker #(
    .SYNC_STAGES  (SYNC_STAGES),
    .HOLD_CYCLES  (HOLD_CYCLES),
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk_slow    (clk_slow),
    .clk_fast    (clk_fast),
    .ext_rst_n   (ext_rst_n),
    .pll_locked  (pll_locked),
    .pll_rst_req (pll_rst_req),
    .slow_rst_n  (slow_rst_n),
    .fast_rst_n  (fast_rst_n)
);

// File: tb/sim_rst_seq_top.sv
`timescale 1ns/1ps
module sim_rst_seq_top;

    localparam int D = 2;
    localparam int H = 5;
    localparam int P = 4;

    logic clk_s = 1'b0;
    logic clk_f = 1'b0;
    logic ext_rst_n;
    logic lock;
    logic pll_rst_req, slow_rst_n, fast_rst_n;

    int   nvec = 0;
    int   nfail = 0;
    realtime last_s_edge = -1.0;
    realtime last_f_edge = -1.0;

    rst_seq_top #(.SYNC_STAGES(D), .HOLD_CYCLES(H), .PULSE_CYCLES(P)) u0 (
        .clk_slow    (clk_s),
        .clk_fast    (clk_f),
        .ext_rst_n   (ext_rst_n),
        .pll_locked  (lock),
        .pll_rst_req (pll_rst_req),
        .slow_rst_n  (slow_rst_n),
        .fast_rst_n  (fast_rst_n)
    );

    // One process makes both clocks so their rising edges share a time step.
    initial begin
        forever begin
            #2.5;
            clk_f = ~clk_f;
            if (clk_f) begin
                last_f_edge = $realtime;
                if (!clk_s) last_s_edge = $realtime;
                clk_s = ~clk_s;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic slow_edges_to_release(output int n);
        n = 0;
        do begin @(posedge clk_s); #1; n++; end while (!slow_rst_n && n < 200);
    endtask

    task automatic fast_edges_to_release(output int n);
        n = 0;
        do begin @(posedge clk_f); #1; n++; end while (!fast_rst_n && n < 200);
    endtask

    task automatic fast_edges_to_pll_low(output int n);
        n = 0;
        do begin @(posedge clk_f); #1; n++; end while (pll_rst_req && n < 200);
    endtask

    task automatic fast_edges_to_pll_high(output int n);
        n = 0;
        do begin @(posedge clk_f); #1; n++; end while (!pll_rst_req && n < 200);
    endtask

    // Fresh external reset cycle, then lock arrives at offset ofs after a slow edge.
    task automatic full_release(input real ofs);
        int n;
        ext_rst_n = 1'b0; lock = 1'b0;
        #7;
        ext_rst_n = 1'b1;
        fast_edges_to_pll_low(n);
        check(n == P, "R6 pll hold after ext release", n, P);
        @(posedge clk_s); #(ofs);
        lock = 1'b1;
        slow_edges_to_release(n);
        check(n == D + H, "R2 slow release latency", n, D + H);
        fast_edges_to_release(n);
        check(n == D, "R3 fast release after slow", n, D);
    endtask

    // R3 ordering monitor.
    always @(posedge clk_f) begin
        #1;
        if (ext_rst_n === 1'b1) check(!(fast_rst_n && !slow_rst_n), "R3 fast before slow", fast_rst_n, 0);
    end

    // R9 and R4 monitors on each release.
    always @(posedge slow_rst_n) begin
        check($realtime == last_s_edge, "R9 slow release on clk_slow edge", 0, 0);
        check(lock === 1'b1, "R4 slow release while unlocked", lock, 1);
    end
    always @(posedge fast_rst_n) begin
        check($realtime == last_f_edge, "R9 fast release on clk_fast edge", 0, 0);
        check(lock === 1'b1, "R4 fast release while unlocked", lock, 1);
    end

    // Watchdog.
    initial begin
        #500000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int n;
        bit quiet;
        ext_rst_n = 1'b0; lock = 1'b0;
        #21;
        check(!slow_rst_n, "R10 reset slow", slow_rst_n, 0);
        check(!fast_rst_n, "R10 reset fast", fast_rst_n, 0);
        check(pll_rst_req, "R10 reset pll request", pll_rst_req, 1);

        // R4: lock with external reset still low releases nothing.
        lock = 1'b1;
        repeat (30) @(posedge clk_f);
        #1;
        check(!slow_rst_n && !fast_rst_n, "R4 lock during ext reset", slow_rst_n | fast_rst_n, 0);
        check(pll_rst_req, "R6 pll high during ext reset", pll_rst_req, 1);

        // R4: external released, lock low stays in reset.
        lock = 1'b0;
        #3.3;
        ext_rst_n = 1'b1;
        repeat (30) @(posedge clk_f);
        #1;
        check(!slow_rst_n && !fast_rst_n, "R4 unlocked after ext release", slow_rst_n | fast_rst_n, 0);

        // R2, R3, R6: sweep lock arrival phase over a slow period.
        for (int k = 0; k < 10; k++) full_release(real'(k) + 0.25);

        // R1: external reset while running clears everything at once.
        repeat (3) @(posedge clk_f);
        #1.3;
        ext_rst_n = 1'b0;
        #0.5;
        check(!slow_rst_n && !fast_rst_n, "R1 async ext assertion", slow_rst_n | fast_rst_n, 0);
        check(pll_rst_req, "R6 async pll request", pll_rst_req, 1);

        // R5: lock lost during the hold count restarts it.
        full_release(3.25);
        ext_rst_n = 1'b0; lock = 1'b0;
        #7;
        ext_rst_n = 1'b1;
        fast_edges_to_pll_low(n);
        @(posedge clk_s); #1.25;
        lock = 1'b1;
        repeat (D + 2) @(posedge clk_s);
        #1;
        check(!slow_rst_n, "R5 still counting", slow_rst_n, 0);
        lock = 1'b0;
        #0.5;
        check(!slow_rst_n && !fast_rst_n, "R1 async unlock mid count", slow_rst_n | fast_rst_n, 0);
        fast_edges_to_pll_high(n);
        fast_edges_to_pll_low(n);
        @(posedge clk_s); #6.25;
        lock = 1'b1;
        slow_edges_to_release(n);
        check(n == D + H, "R5 full count after restart", n, D + H);
        fast_edges_to_release(n);
        check(n == D, "R3 fast release after restart", n, D);

        // R7, R8: loss of lock while running.
        repeat (5) @(posedge clk_f);
        #1.3;
        lock = 1'b0;
        #0.5;
        check(!slow_rst_n && !fast_rst_n, "R1 async unlock while running", slow_rst_n | fast_rst_n, 0);
        fast_edges_to_pll_high(n);
        check(n == D + 1, "R7 pll request latency", n, D + 1);
        fast_edges_to_pll_low(n);
        check(n == P, "R7 pll request length", n, P);
        quiet = 1'b1;
        for (int i = 0; i < 25; i++) begin
            @(posedge clk_f); #1;
            if (pll_rst_req) quiet = 1'b0;
        end
        check(quiet, "R8 no retrigger while unlocked", !quiet, 0);
        check(!slow_rst_n && !fast_rst_n, "R4 still held while unlocked", slow_rst_n | fast_rst_n, 0);
        @(posedge clk_s); #8.25;
        lock = 1'b1;
        slow_edges_to_release(n);
        check(n == D + H, "R2 release after relock", n, D + H);
        fast_edges_to_release(n);
        check(n == D, "R3 fast after relock", n, D);

        // R8: after relock a new loss fires again.
        repeat (4) @(posedge clk_f);
        #2.1;
        lock = 1'b0;
        fast_edges_to_pll_high(n);
        check(n == D + 1, "R8 rearmed after relock", n, D + 1);

        repeat (10) @(posedge clk_f);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule